// File: doc/BRIEF.md
# Fixed-Point Round-to-Upper-Word Stage with Condition Flags

This block is one execute stage of a DSP datapath. It takes a 40-bit fixed-point operand, made of 8 guard bits above a 32-bit word, and rounds it to its upper part. Half of one result LSB (`0x0000_8000`) is added to the whole operand, and the low 16 bits of the sum are then forced to zero. The destination keeps the full 40-bit width. Its significant part is the upper 24 bits, or the upper 16 bits of the 32-bit word when the guard bits are not used.

Every accepted operation updates five condition flags from its own result. Four flags are fixed: negative, zero, overflow and signed-greater-than. The fifth, a configurable "decision" flag, reports whichever condition a 3-bit select field names. Each fixed flag therefore always equals what the decision flag would show if the select field chose that flag's condition.

The result and the flags are captured on a clock edge while the valid strobe is high. They hold their values while the strobe is low.

Top module: `rnd_unit`

## Requirements
- R1: One clock edge after `in_valid` is sampled high, `result` equals `(src_op + 0x00_0000_8000) mod 2^40` with bits 15:0 forced to zero.
- R2: While `in_valid` is low and `rst` is low, `result` and all five flags keep their values, whatever `src_op` and `cond_sel` do.
- R3: A synchronous reset (`rst` high at a clock edge) clears `result` and all five flags to 0. Reset takes priority over `in_valid`.
- R4: After an accepted operation, `flag_n` equals bit 39 of the new `result`.
- R5: After an accepted operation, `flag_z` is 1 exactly when all 40 bits of the new `result` are zero.
- R6: After an accepted operation, `flag_v` is 1 exactly when bit 39 of the source is 0 and bit 39 of the new `result` is 1.
- R7: After an accepted operation, `flag_gt` equals `!(flag_n ^ flag_v) && !flag_z`.
- R8: `flag_dc` follows the `cond_sel` value that was sampled with the operation:
  - 001 gives negative.
  - 010 gives zero.
  - 011 gives overflow.
  - 100 gives signed greater than.
  - 101 gives signed greater-or-equal, `!(N ^ V)`.
  - 110 and 111 give 0.
- R9: With `cond_sel` = 000, `flag_dc` is the carry out of bit 39 of the 41-bit sum `src_op + 0x8000`. It is 1 exactly when `src_op >= 0xFF_FFFF_8000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe that accepts the operand on this edge |
| src_op | input | 40 | Source operand: guard bits 39:32, word 31:0 |
| cond_sel | input | 3 | Condition reported by `flag_dc` |
| result | output | 40 | Rounded value with bits 15:0 cleared |
| flag_dc | output | 1 | Selected condition |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_gt | output | 1 | Signed greater than |

## Verification
Directed operands probe the carry and sign boundaries:
- `0x7F_FFFF_8000` crosses into the sign bit. It sets overflow and negative together, so `flag_gt` stays true.
- `0xFF_FFFF_8000` wraps to zero with a carry out.
- `0x00_0000_7FFF` rounds down to zero without a carry.
- `0x00_0000_8000` rounds up to one result LSB.

Each of these is repeated under all eight select codes. This separates the decision-flag multiplexer from the fixed flags, including the two reserved codes. Random operands with random select codes cover the general sum. Idle cycles with changing inputs, and a mid-run reset, separate the hold behaviour from reset.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    // Encoding of the condition-select field that steers the decision flag.
    typedef enum logic [2:0] {
        SEL_CARRY = 3'b000,
        SEL_NEG   = 3'b001,
        SEL_ZERO  = 3'b010,
        SEL_OVF   = 3'b011,
        SEL_GT    = 3'b100,
        SEL_GE    = 3'b101,
        SEL_RSV6  = 3'b110,
        SEL_RSV7  = 3'b111
    } cond_sel_e;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } flag_t;

    localparam flag_t FLAGS_CLEAR = '{dc: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0, gt: 1'b0};

endpackage

// File: rtl/rnd_add.sv
module rnd_add #(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32
) (
    input  logic [GUARD_W+WORD_W-1:0] src,
    output logic [GUARD_W+WORD_W-1:0] rounded,
    output logic                      carry,
    output logic                      ovf
);
    localparam int DATA_W = GUARD_W + WORD_W;
    localparam int LOW_W  = WORD_W / 2;
    localparam int MSB    = DATA_W - 1;
    localparam logic [DATA_W:0] HALF_LSB = (DATA_W+1)'(1) << (LOW_W - 1);

    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] keep_mask;

    // Mask that keeps the significant upper part and drops the low word.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b < LOW_W) begin : g_drop
            assign keep_mask[b] = 1'b0;
        end else begin : g_keep
            assign keep_mask[b] = 1'b1;
        end
    end

    always_comb begin
        sum     = {1'b0, src} + HALF_LSB;
        rounded = sum[DATA_W-1:0] & keep_mask;
        carry   = sum[DATA_W];
        // Adding a positive constant can only overflow from non-negative to negative.
        ovf     = ~src[MSB] & sum[MSB];
    end

endmodule

// File: rtl/rnd_flags.sv
module rnd_flags
    import rnd_pkg::*;
#(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] rounded,
    input  logic              carry,
    input  logic              ovf,
    input  logic [2:0]        sel,
    output flag_t             flags
);
    logic neg, zero, gt, ge;
    cond_sel_e mode;

    always_comb begin
        neg  = rounded[DATA_W-1];
        zero = ~|rounded;
        ge   = ~(neg ^ ovf);
        gt   = ge & ~zero;
        mode = cond_sel_e'(sel);
    end

    always_comb begin
        flags.n  = neg;
        flags.z  = zero;
        flags.v  = ovf;
        flags.gt = gt;
        unique case (mode)
            SEL_CARRY: flags.dc = carry;
            SEL_NEG:   flags.dc = neg;
            SEL_ZERO:  flags.dc = zero;
            SEL_OVF:   flags.dc = ovf;
            SEL_GT:    flags.dc = gt;
            SEL_GE:    flags.dc = ge;
            SEL_RSV6,
            SEL_RSV7:  flags.dc = 1'b0;
            default:   flags.dc = 1'b0;
        endcase
    end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [GUARD_W+WORD_W-1:0] src_op,
    input  logic [2:0]                cond_sel,
    output logic [GUARD_W+WORD_W-1:0] result,
    output logic                      flag_dc,
    output logic                      flag_n,
    output logic                      flag_z,
    output logic                      flag_v,
    output logic                      flag_gt
);
    localparam int DATA_W = GUARD_W + WORD_W;

    logic [DATA_W-1:0] rnd_val;
    logic              rnd_carry;
    logic              rnd_ovf;
    flag_t             next_flags;
    flag_t             flags_q;
    logic [DATA_W-1:0] result_q;

    rnd_add #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) u_add (
        .src     (src_op),
        .rounded (rnd_val),
        .carry   (rnd_carry),
        .ovf     (rnd_ovf)
    );

    rnd_flags #(.DATA_W(DATA_W)) u_flags (
        .rounded (rnd_val),
        .carry   (rnd_carry),
        .ovf     (rnd_ovf),
        .sel     (cond_sel),
        .flags   (next_flags)
    );

    // State register: loads on an accepted operation, otherwise holds.
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= FLAGS_CLEAR;
        end else if (in_valid) begin
            result_q <= rnd_val;
            flags_q  <= next_flags;
        end
    end

    always_comb begin
        result  = result_q;
        flag_dc = flags_q.dc;
        flag_n  = flags_q.n;
        flag_z  = flags_q.z;
        flag_v  = flags_q.v;
        flag_gt = flags_q.gt;
    end

endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int DATA_W = 40,
    parameter int LOW_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_op,
    input logic [2:0]        cond_sel,
    input logic [DATA_W-1:0] result,
    input logic              flag_dc,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_gt
);
    localparam logic [DATA_W-1:0] HALF = DATA_W'(1) << (LOW_W - 1);

    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    logic [DATA_W-1:0] want;
    always_comb want = (src_op + HALF) & ~((DATA_W'(1) << LOW_W) - DATA_W'(1));

    assert_round_R1: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid |=> result == $past(want));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok && !in_valid |=> $stable(result) && $stable(flag_dc) && $stable(flag_n)
                                 && $stable(flag_z) && $stable(flag_v) && $stable(flag_gt));

    assert_reset_R3: assert property (@(posedge clk)
        past_ok && $past(rst) |-> result == '0 && !flag_dc && !flag_n && !flag_z && !flag_v && !flag_gt);

    assert_neg_R4: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid |=> flag_n == result[DATA_W-1]);

    assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid |=> flag_z == (result == '0));

    assert_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid |=> flag_v == (!$past(src_op[DATA_W-1]) && result[DATA_W-1]));

    assert_gt_R7: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid |=> flag_gt == (!(flag_n ^ flag_v) && !flag_z));

    assert_dc_neg_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid && cond_sel == 3'b001 |=> flag_dc == flag_n);

    assert_dc_gt_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid && cond_sel == 3'b100 |=> flag_dc == flag_gt);

    assert_dc_rsv_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid && cond_sel[2:1] == 2'b11 |=> !flag_dc);

    assert_carry_R9: assert property (@(posedge clk) disable iff (rst)
        past_ok && in_valid && cond_sel == 3'b000 |=> flag_dc == ($past(src_op) >= ~(HALF - DATA_W'(1))));

endmodule

bind rnd_unit rnd_unit_chk #(.DATA_W(GUARD_W + WORD_W), .LOW_W(WORD_W / 2)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_op(src_op), .cond_sel(cond_sel),
    .result(result), .flag_dc(flag_dc), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_gt(flag_gt)
);

// File: tb/sim_rnd_unit.sv
`timescale 1ns/1ps
module sim_rnd_unit;

    typedef struct {
        logic [39:0] res;
        logic        dc, n, z, v, gt;
        logic [2:0]  sel;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [39:0] src_op = '0;
    logic [2:0]  cond_sel = '0;
    logic [39:0] result;
    logic        flag_dc, flag_n, flag_z, flag_v, flag_gt;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];
    exp_t last;

    always #5 clk = ~clk;

    rnd_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_op(src_op), .cond_sel(cond_sel),
        .result(result), .flag_dc(flag_dc), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_gt(flag_gt)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(logic [39:0] s, logic [2:0] sel);
        exp_t e;
        logic [40:0] sum;
        logic ge;
        sum   = {1'b0, s} + 41'h80_00;
        e.res = {sum[39:16], 16'h0000};
        e.n   = e.res[39];
        e.z   = (e.res == 40'd0);
        e.v   = !s[39] && e.res[39];
        ge    = !(e.n ^ e.v);
        e.gt  = ge && !e.z;
        e.sel = sel;
        case (sel)
            3'b000:  e.dc = sum[40];
            3'b001:  e.dc = e.n;
            3'b010:  e.dc = e.z;
            3'b011:  e.dc = e.v;
            3'b100:  e.dc = e.gt;
            3'b101:  e.dc = ge;
            default: e.dc = 1'b0;
        endcase
        return e;
    endfunction

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string ctx, exp_t e);
        chk({ctx, " R1 result"}, result, e.res);
        chk({ctx, " R4 flag_n"}, {39'd0, flag_n}, {39'd0, e.n});
        chk({ctx, " R5 flag_z"}, {39'd0, flag_z}, {39'd0, e.z});
        chk({ctx, " R6 flag_v"}, {39'd0, flag_v}, {39'd0, e.v});
        chk({ctx, " R7 flag_gt"}, {39'd0, flag_gt}, {39'd0, e.gt});
        if (e.sel == 3'b000)
            chk({ctx, " R9 flag_dc carry"}, {39'd0, flag_dc}, {39'd0, e.dc});
        else
            chk({ctx, " R8 flag_dc"}, {39'd0, flag_dc}, {39'd0, e.dc});
    endtask

    task automatic drive(logic [39:0] s, logic [2:0] sel);
        @(negedge clk);
        src_op   = s;
        cond_sel = sel;
        in_valid = 1'b1;
        sb_q.push_back(model(s, sel));
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_op   = {$urandom_range(255, 0), $urandom()};
            cond_sel = 3'($urandom_range(7, 0));
        end
    endtask

    // Monitor: pops the scoreboard on accepted operations, else checks hold/reset.
    initial begin
        exp_t zero_e;
        zero_e = '{res: '0, dc: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0, gt: 1'b0, sel: 3'b111};
        last = zero_e;
        forever begin
            logic fired, was_rst;
            @(posedge clk);
            fired   = in_valid;
            was_rst = rst;
            @(negedge clk);
            #1;
            if (was_rst) begin
                last = zero_e;
                compare_all("R3 reset", zero_e);
            end else if (fired) begin
                if (sb_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R1 scoreboard empty: actual none expected item");
                end else begin
                    last = sb_q.pop_front();
                    compare_all("op", last);
                end
            end else begin
                compare_all("R2 hold", last);
            end
        end
    end

    initial begin
        #1_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [39:0] corners [5];
        corners[0] = 40'h7F_FFFF_8000;
        corners[1] = 40'hFF_FFFF_8000;
        corners[2] = 40'h00_0000_7FFF;
        corners[3] = 40'h00_0000_8000;
        corners[4] = 40'hFF_FFFF_7FFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 5; c++)
            for (int s = 0; s < 8; s++)
                drive(corners[c], 3'(s));
        idle(4);
        for (int i = 0; i < 300; i++) begin
            drive({$urandom_range(255, 0), $urandom()}, 3'($urandom_range(7, 0)));
            if (i % 37 == 0) idle(2);
        end
        // Reset in the middle, with a valid operand present: reset wins (R3).
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; src_op = 40'h12_3456_789A;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        idle(2);
        drive(40'h7F_FFFF_8000, 3'b101);
        drive(40'hFF_FFFF_8000, 3'b000);
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule